// File: doc/BRIEF.md
# Direct-Stepping Gray Code Counter

This block is an N-bit counter whose output walks the reflected Gray code sequence. It holds no binary count and needs no binary-to-Gray conversion. It keeps one extra flag, `stepParity`, which flips on every counting step and tells the counter whether the step count so far is even or odd. On an even step the counter inverts bit 0. On an odd step it inverts the bit just above the lowest set bit. When that lowest set bit is already the most significant bit, the counter inverts the MSB instead, and the sequence wraps to zero.

A control module turns the enable input, the reset input and the parity flag into a small set of strobes. A datapath module holds the Gray register and applies the strobes. Both sit under a thin top. Reset is synchronous and active high. Reset wins over enable.

Top module: `gray_direct_counter`

## Requirements
- R1: A clock edge with `syncReset` high sets `grayOut` to all zeros and clears the internal parity flag.
- R2: Every clock edge with `countEn` high and `syncReset` low changes exactly one bit of `grayOut`.
- R3: On an enabled step taken after an even number of steps since reset (parity flag clear), bit 0 of `grayOut` inverts. Bit 0 therefore inverts once every two enabled steps.
- R4: On an enabled step taken after an odd number of steps, the bit one position above the lowest-order 1 bit of `grayOut` inverts.
- R5: On an odd step where the lowest-order 1 bit is the MSB, the MSB inverts. `grayOut` then returns to zero, so the sequence repeats every 2^N enabled steps.
- R6: A clock edge with `countEn` low and `syncReset` low leaves `grayOut` and the parity flag unchanged. The next enabled step continues the sequence from where it paused.
- R7: After k enabled steps since reset, `grayOut` equals (k mod 2^N) XOR ((k mod 2^N) >> 1). For N=3 the sequence is 000, 001, 011, 010, 110, 111, 101, 100.
- R8: `syncReset` takes priority over `countEn`. A reset in the middle of the sequence, with enable high, restarts the count at zero with parity clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| syncReset | input | 1 | Synchronous active-high reset |
| countEn | input | 1 | Advance the sequence by one step on this edge |
| grayOut | output | WIDTH | Current Gray code value |

## Verification
Every result is due one clock edge after the stimulus. Inputs applied before a rising edge are reflected in `grayOut` just after that edge, because the Gray register feeds the port directly. The driver applies inputs on the falling edge and pushes the value it expects after the following rising edge. The monitor pops that value one time unit after the rising edge, so each comparison lines up with exactly one stimulus cycle. Hold and reset cycles are scored the same way. The parity flag is observed through the port: the step that follows a hold or a reset must produce the expected next code.

// File: rtl/gray_pkg.sv
package gray_pkg;

  // Strobes sent from the control module to the datapath, one set per cycle.
  typedef struct packed {
    logic clear;      // load zero
    logic hold;       // keep the current value
    logic flipLow;    // even step: invert bit 0
    logic flipAbove;  // odd step: invert bit above the lowest set bit
  } grayStrobeT;

endpackage

// File: rtl/gray_step_ctrl.sv
module gray_step_ctrl
  import gray_pkg::*;
(
  input  logic       clk,
  input  logic       syncReset,
  input  logic       countEn,
  output grayStrobeT strobes
);

  logic stepParity;

  always_ff @(posedge clk) begin
    if (syncReset)
      stepParity <= 1'b0;
    else if (countEn)
      stepParity <= ~stepParity;
  end

  always_comb begin
    strobes.clear     = syncReset;
    strobes.hold      = !syncReset && !countEn;
    strobes.flipLow   = !syncReset && countEn && !stepParity;
    strobes.flipAbove = !syncReset && countEn && stepParity;
  end

  // R3: the parity flag alternates on every enabled step.
  assert_parity_flip_R3: assert property (@(posedge clk) disable iff (syncReset)
    countEn |=> (stepParity != $past(stepParity)));

  // R6: the parity flag is frozen while counting is disabled.
  assert_parity_hold_R6: assert property (@(posedge clk) disable iff (syncReset)
    !countEn |=> $stable(stepParity));

  // R1: reset clears the parity flag.
  assert_parity_reset_R1: assert property (@(posedge clk)
    syncReset |=> !stepParity);

  // R8: reset and stepping strobes never coexist.
  assert_reset_priority_R8: assert property (@(posedge clk)
    strobes.clear |-> !(strobes.flipLow || strobes.flipAbove));

endmodule

// File: rtl/gray_step_path.sv
module gray_step_path
  import gray_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  grayStrobeT       strobes,
  output logic [WIDTH-1:0] grayQ
);

  localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [IDXW-1:0] TOP_IDX = IDXW'(WIDTH - 1);

  logic [IDXW-1:0]  lowIdx;
  logic             lowFound;
  logic [IDXW-1:0]  toggleIdx;
  logic [WIDTH-1:0] flipMask;
  logic [WIDTH-1:0] grayNext;

  // Find the lowest-order set bit of the current code.
  always_comb begin
    lowIdx   = '0;
    lowFound = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      if (!lowFound && grayQ[i]) begin
        lowIdx   = IDXW'(i);
        lowFound = 1'b1;
      end
    end
  end

  // Odd step: target the bit one above the lowest set bit. At the MSB, target the MSB itself (wrap).
  assign toggleIdx = (lowIdx == TOP_IDX) ? TOP_IDX : IDXW'(lowIdx + 1'b1);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    if (g == 0) begin : g_lsb
      assign flipMask[g] = strobes.flipLow ||
                           (strobes.flipAbove && toggleIdx == IDXW'(g));
    end else begin : g_upper
      assign flipMask[g] = strobes.flipAbove && toggleIdx == IDXW'(g);
    end
  end

  assign grayNext = grayQ ^ flipMask;

  always_ff @(posedge clk) begin
    if (strobes.clear)
      grayQ <= '0;
    else if (!strobes.hold)
      grayQ <= grayNext;
  end

  // R1: reset loads zero.
  assert_reset_zero_R1: assert property (@(posedge clk)
    strobes.clear |=> (grayQ == '0));

  // R2: a step changes exactly one output bit.
  assert_one_bit_R2: assert property (@(posedge clk) disable iff (strobes.clear)
    (strobes.flipLow || strobes.flipAbove) |=> ($countones(grayQ ^ $past(grayQ)) == 1));

  // R3: an even step inverts bit 0.
  assert_low_flip_R3: assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.flipLow |=> (grayQ[0] != $past(grayQ[0])));

  // R4: an odd step always finds a set bit (parity matches the code's bit count).
  assert_odd_nonzero_R4: assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.flipAbove |-> (grayQ != '0));

  // R6: hold keeps the code.
  assert_hold_R6: assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.hold |=> $stable(grayQ));

endmodule

// File: rtl/gray_direct_counter.sv
module gray_direct_counter
  import gray_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             syncReset,
  input  logic             countEn,
  output logic [WIDTH-1:0] grayOut
);

  grayStrobeT strobes;

  gray_step_ctrl u_ctrl (
    .clk       (clk),
    .syncReset (syncReset),
    .countEn   (countEn),
    .strobes   (strobes)
  );

  gray_step_path #(.WIDTH(WIDTH)) u_path (
    .clk     (clk),
    .strobes (strobes),
    .grayQ   (grayOut)
  );

endmodule

// File: tb/gray_direct_counter_test.sv
module gray_direct_counter_test;

  localparam int N = 4;
  localparam int MOD = 1 << N;

  typedef struct {
    logic [N-1:0] val;
    string        tag;
    bit           isStep;
  } expItemT;

  logic         clk = 1'b0;
  logic         syncReset = 1'b1;
  logic         countEn = 1'b0;
  logic [N-1:0] grayOut;

  int errors = 0;
  int checks = 0;
  int modelK = 0;
  bit done = 0;
  expItemT expQ[$];
  logic [N-1:0] lastSeen = '0;

  gray_direct_counter #(.WIDTH(N)) uut (
    .clk       (clk),
    .syncReset (syncReset),
    .countEn   (countEn),
    .grayOut   (grayOut)
  );

  always #2 clk = ~clk;  // 250 MHz

  function automatic logic [N-1:0] toGray(int k);
    int m;
    m = k % MOD;
    return N'(m ^ (m >> 1));
  endfunction

  // Driver: apply inputs on the falling edge and queue the value due after the next rising edge.
  task automatic drive(bit en, bit rst, string tag);
    expItemT it;
    @(negedge clk);
    countEn   = en;
    syncReset = rst;
    if (rst) modelK = 0;
    else if (en) modelK = (modelK + 1) % MOD;
    it.val    = toGray(modelK);
    it.tag    = tag;
    it.isStep = en && !rst;
    expQ.push_back(it);
  endtask

  // Pick a tag for the next step from the model state.
  function automatic string stepTag();
    logic [N-1:0] g;
    g = toGray(modelK);
    if ((modelK % 2) == 0) return "R3";
    if (g == N'(1 << (N - 1))) return "R5";
    return "R4";
  endfunction

  // Monitor: compare one time unit after each rising edge.
  always @(posedge clk) begin
    expItemT it;
    #1;
    if (expQ.size() > 0) begin
      it = expQ.pop_front();
      checks++;
      if (grayOut !== it.val) begin
        errors++;
        $display("FAIL %s: grayOut actual=%b expected=%b", it.tag, grayOut, it.val);
      end
      if (it.isStep) begin
        checks++;
        if ($countones(grayOut ^ lastSeen) != 1) begin
          errors++;
          $display("FAIL R2: bits changed actual=%0d expected=1 (%b -> %b)",
                   $countones(grayOut ^ lastSeen), lastSeen, grayOut);
        end
      end
      lastSeen = grayOut;
    end
  end

  initial begin
    // R1: reset state
    drive(0, 1, "R1");
    drive(0, 1, "R1");
    // R3 R4 R5: one full lap
    for (int i = 0; i < MOD; i++) drive(1, 0, stepTag());
    // R7: second lap checked against the closed-form sequence
    for (int i = 0; i < MOD + 3; i++) drive(1, 0, "R7");
    // R6: hold with enable low, then continue
    for (int i = 0; i < 3; i++) drive(0, 0, "R6");
    drive(1, 0, "R6");
    drive(0, 0, "R6");
    drive(1, 0, "R6");
    // Alternating enable pattern
    for (int i = 0; i < 10; i++) drive(i % 2 == 0, 0, "R6");
    // R8: reset in mid-sequence with enable high, then restart from zero
    for (int i = 0; i < 5; i++) drive(1, 0, stepTag());
    drive(1, 1, "R8");
    drive(1, 0, "R8");  // must be the first code after zero (parity cleared)
    drive(1, 0, "R8");
    // R1: reset while holding
    drive(0, 1, "R1");
    drive(1, 0, "R1");
    drive(0, 0, "R6");
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule